// File: doc/BRIEF.md
# Counter Host Command Port

This block is the host-facing register front end of a single position-counter channel. The host sees two byte-wide locations: a data location and a control location. A shared byte pointer moves through the three bytes of a 24-bit value, starting with the least significant byte. Writes to the data location build up the preset value. Reads from the data location walk through a snapshot latch of the live count.

Bytes written to the control location are split by their three top bits. Group 000 carries action bits: rewind the pointer, snapshot the count, move the preset into the counter, and clear the flag groups. Groups 001, 010 and 011 load three small configuration registers, which set the count behaviour, the input gating and the index handling. Reading the control location returns a status byte built from the flag inputs. The counting engine itself sits outside this block. It receives one-cycle strobes and static configuration outputs, and it returns its count and flags.

Top module: `ctr_host_port`

## Requirements
- R1: After reset, the preset, the latch, the byte pointer, all configuration outputs and all strobes are zero. This selects normal counting, non-quadrature, inputs disabled, continuous counting, and a non-synchronous, active-low index.
- R2: A write to the data location (port_sel=0) stores wdata into preset byte k, where k is the byte pointer (byte 0 = bits 7:0). The pointer then moves 0→1→2→0.
- R3: A control write whose bits 7:5 are 000 and whose bit 4 is set copies count_in into the latch. A read of the data location returns latch byte k, where k is the byte pointer, and advances the pointer the same way as R2.
- R4: A control write whose bits 7:5 are 000 and whose bit 0 is set returns the pointer to byte 0. It touches neither the latch nor the preset.
- R5: A control write whose bits 7:5 are 000 and whose bit 3 is set raises load_count_stb for exactly the one cycle after the write.
- R6: In a group-000 control write, bits 2:1 control the clears. Bits 2:1 equal to 01 or 10 pulse clr_flags_stb for one cycle. Bits 2:1 equal to 11 pulse clr_error_stb instead.
- R7: A control write with bits 7:5 = 001 sets count_mode from bits 2:1 (0 normal, 1 range limit, 2 non-recycle, 3 modulo-N). It sets quad_factor from bits 4:3 (0 non-quadrature, 1/2/3 = x1/x2/x4).
- R8: A control write with bits 7:5 = 010 sets ab_enable from bit 0 and index_preset from bit 1.
- R9: A control write with bits 7:5 = 011 sets index_pol from bit 1 and index_sync from bit 0.
- R10: A read of the control location returns {2'b00, dir_up_in, noise_in, 2'b00, carry_in, borrow_in}. rdata is zero in any cycle without a read.
- R11: index_sync is never 1 while quad_factor is 0. Loading quad_factor=0 clears index_sync. An index write made while quad_factor is 0 stores index_sync as 0.
- R12: A control write with bit 7 set changes no output or state. A read of the control location leaves the byte pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the data location, 1 selects the control location |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational, valid during rd_en) |
| count_in | input | 24 | Live count from the counting engine |
| borrow_in | input | 1 | Borrow flag from the engine |
| carry_in | input | 1 | Carry flag from the engine |
| noise_in | input | 1 | Input noise error flag |
| dir_up_in | input | 1 | Count direction, 1 = up |
| preset_out | output | 24 | Preset value |
| load_count_stb | output | 1 | Load preset into counter |
| clr_flags_stb | output | 1 | Clear borrow/carry/compare/sign flags |
| clr_error_stb | output | 1 | Clear noise error flag |
| count_mode | output | 2 | Count behaviour |
| quad_factor | output | 2 | Quadrature factor, 0 = non-quadrature |
| ab_enable | output | 1 | Enable A/B count inputs |
| index_preset | output | 1 | 1 = preset on index, 0 = continuous |
| index_sync | output | 1 | Synchronous index mode |
| index_pol | output | 1 | Index active level, 1 = high |

## Verification
The properties assume that the host never reads and writes in the same cycle, because a combined access would let two pointer updates and a command coincide. The properties also take each status flag input as a plain level that is sampled during the read cycle. The stimulus keeps to these assumptions. It issues every access from a single task that drives exactly one of wr_en and rd_en for one cycle and then returns to idle, and it changes the flag and count inputs only between accesses.

// File: rtl/chp_pkg.sv
package chp_pkg;

  typedef enum logic [2:0] {
    GRP_CMD   = 3'b000,
    GRP_MODE  = 3'b001,
    GRP_IO    = 3'b010,
    GRP_INDEX = 3'b011
  } grp_e;

  typedef struct packed {
    logic [1:0] count_mode;
    logic [1:0] quad;
    logic       ab_en;
    logic       idx_preset;
    logic       idx_sync;
    logic       idx_pol;
  } cfg_t;

  typedef struct packed {
    logic ptr_clr;
    logic latch;
    logic load;
    logic flag_clr;
    logic err_clr;
    logic mode_we;
    logic io_we;
    logic idx_we;
  } cmd_t;

  // next byte position with wrap after the last lane
  function automatic int unsigned ptr_after(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // split a control byte into its actions
  function automatic cmd_t decode_cmd(logic [7:0] b, logic hit);
    cmd_t c;
    c = '0;
    if (hit) begin
      case (b[7:5])
        GRP_CMD: begin
          c.ptr_clr  = b[0];
          c.load     = b[3];
          c.latch    = b[4];
          c.flag_clr = (b[2:1] == 2'b01) || (b[2:1] == 2'b10);
          c.err_clr  = (b[2:1] == 2'b11);
        end
        GRP_MODE:  c.mode_we = 1'b1;
        GRP_IO:    c.io_we   = 1'b1;
        GRP_INDEX: c.idx_we  = 1'b1;
        default:   c = '0;
      endcase
    end
    return c;
  endfunction

  function automatic logic [7:0] status_pack(logic borrow, logic carry,
                                             logic noise, logic dir_up);
    return {2'b00, dir_up, noise, 2'b00, carry, borrow};
  endfunction

endpackage

// File: rtl/chp_byte_ptr.sv
module chp_byte_ptr
  import chp_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int PTR_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);

  logic [PTR_W-1:0] ptr_nxt;

  assign ptr_nxt = PTR_W'(ptr_after(32'(ptr_q), NUM_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (clr)   ptr_q <= '0;
    else if (step)  ptr_q <= ptr_nxt;
  end

endmodule

// File: rtl/chp_preset_reg.sv
module chp_preset_reg #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int PTR_W     = 2,
  localparam int VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [VAL_W-1:0]  value
);

  logic [BYTE_W-1:0] lane_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q[g] <= '0;
      else if (byte_we && (ptr == PTR_W'(g)))
        lane_q[g] <= byte_in;
    end
    assign value[g*BYTE_W +: BYTE_W] = lane_q[g];
  end

endmodule

// File: rtl/chp_latch_reg.sv
module chp_latch_reg #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int PTR_W     = 2,
  localparam int VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [VAL_W-1:0]  word_in,
  input  logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] byte_out
);

  logic [VAL_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= word_in;
  end

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (ptr == PTR_W'(i)) byte_out = snap_q[i*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/chp_cfg_regs.sv
module chp_cfg_regs
  import chp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       io_we,
  input  logic       idx_we,
  input  logic [7:0] cfg_byte,
  output cfg_t       cfg_q
);

  logic quad_off_new;
  logic quad_off_now;

  assign quad_off_new = (cfg_byte[4:3] == 2'b00);
  assign quad_off_now = (cfg_q.quad == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (mode_we) begin
        cfg_q.count_mode <= cfg_byte[2:1];
        cfg_q.quad       <= cfg_byte[4:3];
        if (quad_off_new) cfg_q.idx_sync <= 1'b0;
      end
      if (io_we) begin
        cfg_q.ab_en      <= cfg_byte[0];
        cfg_q.idx_preset <= cfg_byte[1];
      end
      if (idx_we) begin
        cfg_q.idx_sync <= cfg_byte[0] & ~quad_off_now;
        cfg_q.idx_pol  <= cfg_byte[1];
      end
    end
  end

endmodule

// File: rtl/ctr_host_port.sv
module ctr_host_port
  import chp_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        port_sel,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [BYTE_W-1:0]           wdata,
  output logic [BYTE_W-1:0]           rdata,
  input  logic [BYTE_W*NUM_BYTES-1:0] count_in,
  input  logic                        borrow_in,
  input  logic                        carry_in,
  input  logic                        noise_in,
  input  logic                        dir_up_in,
  output logic [BYTE_W*NUM_BYTES-1:0] preset_out,
  output logic                        load_count_stb,
  output logic                        clr_flags_stb,
  output logic                        clr_error_stb,
  output logic [1:0]                  count_mode,
  output logic [1:0]                  quad_factor,
  output logic                        ab_enable,
  output logic                        index_preset,
  output logic                        index_sync,
  output logic                        index_pol
);

  localparam int VAL_W = BYTE_W * NUM_BYTES;
  localparam int PTR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  // access classes
  logic data_wr, data_rd, ctrl_wr, ctrl_rd;
  assign data_wr = wr_en & ~port_sel;
  assign data_rd = rd_en & ~port_sel;
  assign ctrl_wr = wr_en &  port_sel;
  assign ctrl_rd = rd_en &  port_sel;

  // command decode event
  cmd_t cmd;
  assign cmd = decode_cmd(wdata[7:0], ctrl_wr);

  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] latch_byte;
  cfg_t              cfg_q;

  chp_byte_ptr #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd.ptr_clr),
    .step  (data_wr | data_rd),
    .ptr_q (ptr_q)
  );

  chp_preset_reg #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_preset (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (data_wr),
    .ptr     (ptr_q),
    .byte_in (wdata),
    .value   (preset_out)
  );

  chp_latch_reg #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (cmd.latch),
    .word_in  (count_in),
    .ptr      (ptr_q),
    .byte_out (latch_byte)
  );

  chp_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (cmd.mode_we),
    .io_we    (cmd.io_we),
    .idx_we   (cmd.idx_we),
    .cfg_byte (wdata[7:0]),
    .cfg_q    (cfg_q)
  );

  // one-cycle strobes toward the counting engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_count_stb <= 1'b0;
      clr_flags_stb  <= 1'b0;
      clr_error_stb  <= 1'b0;
    end else begin
      load_count_stb <= cmd.load;
      clr_flags_stb  <= cmd.flag_clr;
      clr_error_stb  <= cmd.err_clr;
    end
  end

  logic [BYTE_W-1:0] status_byte;
  assign status_byte = BYTE_W'(status_pack(borrow_in, carry_in, noise_in, dir_up_in));

  assign rdata = data_rd ? latch_byte :
                 ctrl_rd ? status_byte : '0;

  assign count_mode   = cfg_q.count_mode;
  assign quad_factor  = cfg_q.quad;
  assign ab_enable    = cfg_q.ab_en;
  assign index_preset = cfg_q.idx_preset;
  assign index_sync   = cfg_q.idx_sync;
  assign index_pol    = cfg_q.idx_pol;

endmodule

// File: rtl/chp_checker.sv
module chp_checker #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int PTR_W     = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        port_sel,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [BYTE_W-1:0]           wdata,
  input logic [BYTE_W-1:0]           rdata,
  input logic                        borrow_in,
  input logic                        carry_in,
  input logic                        noise_in,
  input logic                        dir_up_in,
  input logic [BYTE_W*NUM_BYTES-1:0] preset_out,
  input logic                        load_count_stb,
  input logic                        clr_flags_stb,
  input logic                        clr_error_stb,
  input logic [1:0]                  count_mode,
  input logic [1:0]                  quad_factor,
  input logic                        ab_enable,
  input logic                        index_preset,
  input logic                        index_sync,
  input logic                        index_pol,
  input logic [PTR_W-1:0]            ptr_q
);

  logic ctrl_wr, data_acc, grp_cmd;
  assign ctrl_wr  = wr_en & port_sel & ~rd_en;
  assign data_acc = (wr_en ^ rd_en) & ~port_sel;
  assign grp_cmd  = ctrl_wr & (wdata[7:5] == 3'b000);

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < PTR_W'(NUM_BYTES));

  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && (ptr_q == PTR_W'(NUM_BYTES - 1)) |=> ptr_q == '0);

  assert_ptr_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_cmd && wdata[0] |=> ptr_q == '0);

  assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grp_cmd && wdata[3] |=> load_count_stb);

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_cmd && (wdata[2:1] == 2'b11) |=> clr_error_stb && !clr_flags_stb);

  assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (wdata[7:5] == 3'b001) |=>
      count_mode == $past(wdata[2:1]) && quad_factor == $past(wdata[4:3]));

  assert_io_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (wdata[7:5] == 3'b010) |=>
      ab_enable == $past(wdata[0]) && index_preset == $past(wdata[1]));

  assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && port_sel && !wr_en |->
      rdata[5:0] == {dir_up_in, noise_in, 2'b00, carry_in, borrow_in});

  assert_sync_needs_quad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    index_sync |-> quad_factor != 2'b00);

  assert_ignored_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wdata[7] |=>
      $stable(preset_out) && $stable(count_mode) && $stable(quad_factor) &&
      $stable(ab_enable) && $stable(index_preset) && $stable(index_sync) &&
      $stable(index_pol) && $stable(ptr_q) &&
      !load_count_stb && !clr_flags_stb && !clr_error_stb);

  assert_status_read_holds_ptr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && port_sel && !wr_en |=> $stable(ptr_q));

endmodule

bind ctr_host_port chp_checker #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .borrow_in(borrow_in), .carry_in(carry_in),
  .noise_in(noise_in), .dir_up_in(dir_up_in), .preset_out(preset_out),
  .load_count_stb(load_count_stb), .clr_flags_stb(clr_flags_stb),
  .clr_error_stb(clr_error_stb), .count_mode(count_mode),
  .quad_factor(quad_factor), .ab_enable(ab_enable), .index_preset(index_preset),
  .index_sync(index_sync), .index_pol(index_pol), .ptr_q(ptr_q)
);

// File: tb/tb_ctr_host_port.sv
`timescale 1ns/1ps
module tb_ctr_host_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] count_in = '0;
  logic        borrow_in = 1'b0, carry_in = 1'b0, noise_in = 1'b0, dir_up_in = 1'b0;
  logic [23:0] preset_out;
  logic        load_count_stb, clr_flags_stb, clr_error_stb;
  logic [1:0]  count_mode, quad_factor;
  logic        ab_enable, index_preset, index_sync, index_pol;

  always #10 clk = ~clk;   // 50 MHz

  ctr_host_port dut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .count_in(count_in), .borrow_in(borrow_in),
    .carry_in(carry_in), .noise_in(noise_in), .dir_up_in(dir_up_in),
    .preset_out(preset_out), .load_count_stb(load_count_stb),
    .clr_flags_stb(clr_flags_stb), .clr_error_stb(clr_error_stb),
    .count_mode(count_mode), .quad_factor(quad_factor), .ab_enable(ab_enable),
    .index_preset(index_preset), .index_sync(index_sync), .index_pol(index_pol)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_bp, m_preset, m_latch, m_mode, m_quad, m_ab, m_ip, m_sync, m_pol;
  int m_load, m_fclr, m_eclr;
  bit cmp_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bp = 0; m_preset = 0; m_latch = 0; m_mode = 0; m_quad = 0;
      m_ab = 0; m_ip = 0; m_sync = 0; m_pol = 0;
      m_load = 0; m_fclr = 0; m_eclr = 0;
    end else begin
      m_load = 0; m_fclr = 0; m_eclr = 0;
      if (wr_en && !port_sel) begin
        m_preset = (m_preset & ~(255 << (8 * m_bp))) | (int'(wdata) << (8 * m_bp));
        m_bp = (m_bp + 1) % 3;
      end else if (rd_en && !port_sel) begin
        m_bp = (m_bp + 1) % 3;
      end else if (wr_en && port_sel) begin
        case (wdata[7:5])
          3'd0: begin
            if (wdata[4]) m_latch = int'(count_in);
            if (wdata[3]) m_load = 1;
            if (wdata[2:1] == 2'b11) m_eclr = 1;
            else if (wdata[2:1] != 2'b00) m_fclr = 1;
            if (wdata[0]) m_bp = 0;
          end
          3'd1: begin
            m_mode = int'(wdata[2:1]);
            m_quad = int'(wdata[4:3]);
            if (m_quad == 0) m_sync = 0;
          end
          3'd2: begin m_ab = int'(wdata[0]); m_ip = int'(wdata[1]); end
          3'd3: begin
            m_sync = (wdata[0] && m_quad != 0) ? 1 : 0;
            m_pol  = int'(wdata[1]);
          end
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int exp_rd;
      chk("R2 preset", 32'(preset_out), m_preset);
      chk("R5 load strobe", 32'(load_count_stb), m_load);
      chk("R6 flag strobe", 32'(clr_flags_stb), m_fclr);
      chk("R6 error strobe", 32'(clr_error_stb), m_eclr);
      chk("R7 count_mode", 32'(count_mode), m_mode);
      chk("R7 quad_factor", 32'(quad_factor), m_quad);
      chk("R8 ab_enable", 32'(ab_enable), m_ab);
      chk("R8 index_preset", 32'(index_preset), m_ip);
      chk("R11 index_sync", 32'(index_sync), m_sync);
      chk("R9 index_pol", 32'(index_pol), m_pol);
      if (rd_en && port_sel)
        exp_rd = (int'(dir_up_in) << 5) | (int'(noise_in) << 4) |
                 (int'(carry_in) << 1) | int'(borrow_in);
      else if (rd_en)
        exp_rd = (m_latch >> (8 * m_bp)) & 255;
      else
        exp_rd = 0;
      chk(port_sel ? "R10 rdata" : "R3 rdata", 32'(rdata), exp_rd);
    end
  end

  task automatic acc(bit sel, bit w, bit r, logic [7:0] d);
    @(posedge clk); #2;
    port_sel = sel; wr_en = w; rd_en = r; wdata = d;
    @(posedge clk); #2;
    port_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_exp(bit sel, logic [7:0] exp, string tag);
    @(posedge clk); #2;
    port_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    chk(tag, 32'(rdata), 32'(exp));
    @(posedge clk); #2;
    port_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 preset", 32'(preset_out), 0);
    chk("R1 strobes", 32'({load_count_stb, clr_flags_stb, clr_error_stb}), 0);
    chk("R1 config", 32'({count_mode, quad_factor, ab_enable, index_preset,
                          index_sync, index_pol}), 0);
    chk("R1 rdata", 32'(rdata), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    cmp_on = 1'b1;
    rd_exp(0, 8'h00, "R1 latch");

    // R2 preset loading LSB first, with wrap
    acc(1, 1, 0, 8'h01);
    acc(0, 1, 0, 8'h56); acc(0, 1, 0, 8'h34); acc(0, 1, 0, 8'h12);
    @(negedge clk); chk("R2 preset assembled", 32'(preset_out), 32'h123456);
    acc(0, 1, 0, 8'hAA);
    @(negedge clk); chk("R2 pointer wrap", 32'(preset_out), 32'h1234AA);

    // R3 latch and LSB-first readout
    count_in = 24'hA5B6C7;
    acc(1, 1, 0, 8'h11);
    count_in = 24'h000000;
    rd_exp(0, 8'hC7, "R3 byte0");
    rd_exp(0, 8'hB6, "R3 byte1");
    rd_exp(0, 8'hA5, "R3 byte2");
    rd_exp(0, 8'hC7, "R3 wrap");

    // R4 rewind only
    acc(1, 1, 0, 8'h01);
    rd_exp(0, 8'hC7, "R4 rewind keeps latch");
    rd_exp(0, 8'hB6, "R4 continue");
    @(negedge clk); chk("R4 preset untouched", 32'(preset_out), 32'h1234AA);

    // R5 load strobe
    acc(1, 1, 0, 8'h08);
    @(negedge clk); chk("R5 load high", 32'(load_count_stb), 1);
    @(negedge clk); chk("R5 load one cycle", 32'(load_count_stb), 0);

    // R6 clears
    acc(1, 1, 0, 8'h02);
    @(negedge clk); chk("R6 flags 01", 32'({clr_flags_stb, clr_error_stb}), 2);
    acc(1, 1, 0, 8'h04);
    @(negedge clk); chk("R6 flags 10", 32'({clr_flags_stb, clr_error_stb}), 2);
    acc(1, 1, 0, 8'h06);
    @(negedge clk); chk("R6 error 11", 32'({clr_flags_stb, clr_error_stb}), 1);

    // R7 mode register
    acc(1, 1, 0, 8'h3A);
    @(negedge clk);
    chk("R7 mode", 32'(count_mode), 1);
    chk("R7 quad", 32'(quad_factor), 3);

    // R8 I/O register
    acc(1, 1, 0, 8'h43);
    @(negedge clk); chk("R8 io 11", 32'({ab_enable, index_preset}), 3);
    acc(1, 1, 0, 8'h41);
    @(negedge clk); chk("R8 io 01", 32'({ab_enable, index_preset}), 2);

    // R9 index register
    acc(1, 1, 0, 8'h63);
    @(negedge clk); chk("R9 sync/pol", 32'({index_sync, index_pol}), 3);

    // R11 sync requires quadrature
    acc(1, 1, 0, 8'h22);
    @(negedge clk); chk("R11 cleared by non-quad", 32'({index_sync, index_pol}), 1);
    acc(1, 1, 0, 8'h63);
    @(negedge clk); chk("R11 refused in non-quad", 32'(index_sync), 0);
    acc(1, 1, 0, 8'h28);
    @(negedge clk); chk("R11 stays off", 32'(index_sync), 0);
    acc(1, 1, 0, 8'h61);
    @(negedge clk); chk("R11 allowed in quad", 32'({index_sync, index_pol}), 2);

    // R10 status byte
    borrow_in = 1'b1; carry_in = 1'b0; noise_in = 1'b1; dir_up_in = 1'b1;
    rd_exp(1, 8'h31, "R10 status a");
    borrow_in = 1'b0; carry_in = 1'b1; noise_in = 1'b0; dir_up_in = 1'b0;
    rd_exp(1, 8'h02, "R10 status b");

    // R12 ignored group and status read leave state alone
    acc(1, 1, 0, 8'hFF);
    acc(1, 1, 0, 8'hA0);
    @(negedge clk);
    chk("R12 preset", 32'(preset_out), 32'h1234AA);
    chk("R12 config", 32'({count_mode, quad_factor, ab_enable, index_preset,
                           index_sync, index_pol}), 32'({2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0}));
    chk("R12 strobes", 32'({load_count_stb, clr_flags_stb, clr_error_stb}), 0);
    count_in = 24'h030201;
    acc(1, 1, 0, 8'h11);
    rd_exp(0, 8'h01, "R12 byte0");
    rd_exp(1, 8'h02, "R12 status between");
    rd_exp(0, 8'h02, "R12 pointer held");
    acc(0, 1, 0, 8'h77);
    @(negedge clk); chk("R12 write after status", 32'(preset_out), 32'h7734AA);

    repeat (3) @(posedge clk);
    finished = 1'b1;
    report();
  end

endmodule